// File: doc/BRIEF.md
# Grouped-priority interrupt controller

This block collects eighteen interrupt request lines and presents one winning vector to the processor. The sources are arranged in six groups of three. Each group carries a 2-bit priority level, so there are four levels in all. Among the pending, enabled sources, the one at the highest level wins. When several sources share that level, the lowest source index wins.

The processor accepts a vector by pulsing acknowledge. That clears the source's pending flag and enters the vector's level. A later request preempts the running handler only if its level is strictly higher. The active levels form a nesting stack up to four deep, and a return-from-interrupt pulse leaves the innermost level. A global enable hides the vector output.

While the core sleeps, a fixed subset of sources can raise a wake request. These stand for the I/O and timer lines. The wake request is not affected by the global enable.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset no source is pending or enabled, no level is active, the global enable is off, and `irq_valid_o` and `wake_o` are low.
- R2: A high bit on `req_i` at a clock edge sets that source's pending flag. The flag stays set until that source is acknowledged. A request in the same cycle as the acknowledge keeps the flag set.
- R3: A source whose bit was written 0 through `en_we_i`/`en_d_i` is never presented. Its pending flag is kept and becomes visible once the source is enabled again.
- R4: With the global enable written 0 through `gie_we_i`/`gie_d_i`, `irq_valid_o` stays low. Pending flags are kept.
- R5: Sources 3g, 3g+1 and 3g+2 share the level in bits [2g+1:2g] of the value written through `prio_we_i`/`prio_d_i`. A numerically higher level wins over a lower one.
- R6: Among candidates at the same winning level, the lowest source index is presented.
- R7: An acknowledge while `irq_valid_o` is high clears the pending flag of `irq_vec_o` and makes `irq_lvl_o` the active level. An acknowledge while `irq_valid_o` is low has no effect.
- R8: While a level is active, a candidate is presented only if its level is strictly higher than the innermost active level.
- R9: `reti_i` leaves the innermost active level, which restores the level that was active before it. With no level active it does nothing. An acknowledge in the same cycle as `reti_i` is ignored.
- R10: `wake_o` is high while `sleep_i` is high and any pending, enabled source from the wake set {0, 1, 6, 7} exists, independent of the global enable.
- R11: `irq_lvl_o` gives the level of the presented vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 18 | Request lines, one per source |
| en_we_i | input | 1 | Write strobe for the source enables |
| en_d_i | input | 18 | New source enable mask |
| prio_we_i | input | 1 | Write strobe for the group levels |
| prio_d_i | input | 12 | Six 2-bit group levels |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_d_i | input | 1 | New global enable value |
| ack_i | input | 1 | Processor accepts the presented vector |
| reti_i | input | 1 | Processor returns from the innermost handler |
| sleep_i | input | 1 | Core is in a sleep state |
| irq_valid_o | output | 1 | A vector is presented |
| irq_vec_o | output | 5 | Presented source index |
| irq_lvl_o | output | 2 | Level of the presented source |
| wake_o | output | 1 | Wake request to leave sleep |

## Verification
Four properties are checked on every cycle:
- an accepted vector loses its pending flag unless it is requested again;
- an accepted vector's level becomes active;
- a presented vector is always pending and enabled;
- a return pops exactly one active level.

Arbitration order across groups and indices, the strictly-higher preemption rule over deep nesting, masking by the enables, and wake generation under a disabled global enable are shown only by the bench. Its behavioural model, which uses a queue as the nesting stack, is compared against the outputs every cycle, through directed scenarios and a long randomised run.

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NSRC     = 18,
  parameter int GRP_SIZE = 3,
  parameter int NLVL     = 4,
  parameter logic [NSRC-1:0] WAKE_SRC = 'h000C3,
  localparam int NGRP = NSRC / GRP_SIZE,
  localparam int LW   = $clog2(NLVL),
  localparam int IW   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             en_we_i,
  input  logic [NSRC-1:0]  en_d_i,
  input  logic             prio_we_i,
  input  logic [NGRP*LW-1:0] prio_d_i,
  input  logic             gie_we_i,
  input  logic             gie_d_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             sleep_i,
  output logic             irq_valid_o,
  output logic [IW-1:0]    irq_vec_o,
  output logic [LW-1:0]    irq_lvl_o,
  output logic             wake_o
);

  logic [NSRC-1:0]    pend_q, en_q;
  logic [NGRP*LW-1:0] prio_q;
  logic               gie_q;
  logic [NLVL-1:0]    active_q;

  logic               found, busy, take;
  logic [IW-1:0]      best_idx;
  logic [LW-1:0]      best_lvl, cur_lvl, sl;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    sl       = '0;
    for (int i = 0; i < NSRC; i++) begin
      sl = prio_q[(i / GRP_SIZE) * LW +: LW];
      if (pend_q[i] && en_q[i] && (!found || sl > best_lvl)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_lvl = sl;
      end
    end
  end

  always_comb begin
    cur_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (active_q[l]) cur_lvl = LW'(l);
  end

  assign busy        = |active_q;
  assign irq_valid_o = gie_q && found && (!busy || best_lvl > cur_lvl);
  assign irq_vec_o   = best_idx;
  assign irq_lvl_o   = best_lvl;
  assign take        = ack_i && irq_valid_o && !reti_i;
  assign wake_o      = sleep_i && |(pend_q & en_q & WAKE_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      en_q     <= '0;
      prio_q   <= '0;
      gie_q    <= 1'b0;
      active_q <= '0;
    end else begin
      if (reti_i && busy)
        active_q[cur_lvl] <= 1'b0;
      else if (take)
        active_q[best_lvl] <= 1'b1;
      if (en_we_i)   en_q   <= en_d_i;
      if (prio_we_i) prio_q <= prio_d_i;
      if (gie_we_i)  gie_q  <= gie_d_i;
      pend_q <= (pend_q & ~(take ? (NSRC'(1) << best_idx) : '0)) | req_i;
    end
  end

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && irq_valid_o && !reti_i && !req_i[irq_vec_o] |=> !pend_q[$past(irq_vec_o)]);

  a_r7_level_entered: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && irq_valid_o && !reti_i |=> active_q[$past(irq_lvl_o)]);

  a_r3_vector_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> en_q[irq_vec_o] && pend_q[irq_vec_o]);

  a_r9_reti_pops: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i && busy |=> $countones(active_q) == $countones($past(active_q)) - 1);

endmodule

// File: tb/test_grp_irq_ctrl.sv
`timescale 1ns/1ps
module test_grp_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [17:0] req_i = '0, en_d_i = '0;
  logic en_we_i = 0, prio_we_i = 0, gie_we_i = 0, gie_d_i = 0;
  logic [11:0] prio_d_i = '0;
  logic ack_i = 0, reti_i = 0, sleep_i = 0;
  logic irq_valid_o, wake_o;
  logic [4:0] irq_vec_o;
  logic [1:0] irq_lvl_o;

  grp_irq_ctrl i_grp_irq_ctrl (.*);

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  string phase = "R1 reset";
  bit started = 0;

  bit m_pend[18], m_en[18];
  int m_prio[6];
  bit m_gie;
  int stk[$];

  function automatic bit is_wake(int i);
    return i == 0 || i == 1 || i == 6 || i == 7;
  endfunction

  function automatic void m_eval(output bit v, output int idx, output int lvl, output bit w);
    bit f = 0;
    idx = 0; lvl = 0; w = 0;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < 18; i++)
        if (!f && m_pend[i] && m_en[i] && m_prio[i/3] == l) begin f = 1; idx = i; lvl = l; end
    v = m_gie && f && (stk.size() == 0 || lvl > stk[$]);
    for (int i = 0; i < 18; i++)
      if (m_pend[i] && m_en[i] && is_wake(i) && sleep_i) w = 1;
  endfunction

  always @(posedge clk) begin
    bit v, w; int idx, lvl;
    started <= 1;
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; end
      foreach (m_prio[g]) m_prio[g] = 0;
      m_gie = 0; stk.delete();
    end else begin
      m_eval(v, idx, lvl, w);
      if (reti_i) begin if (stk.size() > 0) void'(stk.pop_back()); end
      else if (ack_i && v) begin m_pend[idx] = 0; stk.push_back(lvl); end
      if (en_we_i) foreach (m_en[i]) m_en[i] = en_d_i[i];
      if (prio_we_i) foreach (m_prio[g]) m_prio[g] = int'((prio_d_i >> (2*g)) & 12'd3);
      if (gie_we_i) m_gie = gie_d_i;
      foreach (m_pend[i]) if (req_i[i]) m_pend[i] = 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit v, w; int idx, lvl;
    #1;
    if (started) begin
      m_eval(v, idx, lvl, w);
      chk("valid", int'(irq_valid_o), int'(v));
      chk("wake", int'(wake_o), int'(w));
      if (v) begin
        chk("vector", int'(irq_vec_o), idx);
        chk("level (R11)", int'(irq_lvl_o), lvl);
      end
    end
  end

  task automatic step(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic req(int i); req_i = 18'(1) << i; step(); req_i = '0; endtask
  task automatic req2(int a, int b); req_i = (18'(1) << a) | (18'(1) << b); step(); req_i = '0; endtask
  task automatic ack(); ack_i = 1; step(); ack_i = 0; endtask
  task automatic reti(); reti_i = 1; step(); reti_i = 0; endtask
  task automatic wr_en(logic [17:0] v); en_we_i = 1; en_d_i = v; step(); en_we_i = 0; endtask
  task automatic wr_prio(logic [11:0] v); prio_we_i = 1; prio_d_i = v; step(); prio_we_i = 0; endtask
  task automatic wr_gie(bit v); gie_we_i = 1; gie_d_i = v; step(); gie_we_i = 0; endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);

    phase = "R2 pending latch";
    wr_en('1); wr_gie(1);
    req(5); step(2);
    phase = "R7 acknowledge";
    ack(); step();
    ack(); step();

    phase = "R3 source enable";
    wr_en(~(18'(1) << 4));
    req(4); step(2);
    wr_en('1); step();
    ack();

    phase = "R4 global enable";
    wr_gie(0); req(2); step(2);
    wr_gie(1); step(); ack();

    phase = "R5 group level";
    wr_prio(12'h030);
    req2(1, 7); step();
    ack(); reti(); ack(); reti();

    phase = "R6 index order";
    wr_prio(12'h000);
    req2(14, 9); step(); ack(); reti();
    req_i = 18'h00E00; step(); req_i = '0;
    ack(); reti(); ack(); reti(); ack(); reti();

    phase = "R8 nesting";
    wr_prio(12'h034);
    req(0); ack();
    req(1); step(2);
    req(3); ack();
    req(6); ack();
    req(7); step(2);
    phase = "R9 return";
    reti(); step(); ack();
    reti(); reti(); step();
    reti(); step(); ack();
    reti(); reti(); step();
    req(2); ack_i = 1; reti_i = 1; step(); ack_i = 0; reti_i = 0;
    ack(); reti();
    req(8); req_i = 18'(1) << 8; ack_i = 1; step(); req_i = '0; ack_i = 0;
    step(); ack(); reti(); reti();

    phase = "R10 wake";
    wr_gie(0); sleep_i = 1;
    req(10); step(2);
    req(6); step(2);
    sleep_i = 0; step();
    wr_gie(1); ack(); reti(); ack(); reti();

    phase = "random R7 R8 R9 R10";
    for (int c = 0; c < 4000; c++) begin
      req_i     = ($urandom % 4 == 0) ? (18'(1) << ($urandom % 18)) : '0;
      ack_i     = ($urandom % 3 == 0);
      reti_i    = ($urandom % 5 == 0);
      sleep_i   = ($urandom % 4 == 0);
      prio_we_i = ($urandom % 60 == 0); prio_d_i = 12'($urandom);
      en_we_i   = ($urandom % 80 == 0); en_d_i = 18'($urandom) | 18'($urandom);
      gie_we_i  = ($urandom % 90 == 0); gie_d_i = ($urandom % 4 != 0);
      step();
    end
    req_i = '0; ack_i = 0; reti_i = 0; prio_we_i = 0; en_we_i = 0; gie_we_i = 0;
    step(2);

    phase = "R1 reset";
    rst_n = 0; step(2); rst_n = 1; step(2);
    finish_run();
  end
endmodule